// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a single successive-approximation conversion engine across sixteen analog inputs. It chooses the input to convert, pulses a start to the engine, waits for the engine's done strobe and captures the returned 10-bit code into a register kept for that input. The engine itself and the register bus sit outside; the engine is seen only through a start/done handshake, and stored codes are read through a combinational read port.

Two operating styles exist. In single mode one chosen input is converted once. In scan mode a group of the lowest 4, 8 or 16 inputs is converted in ascending order, either for one pass or repeatedly until software withdraws the run bit. A run may be launched by a software set pulse, by an on-chip event strobe, or by the rising edge of an asynchronous trigger pin. The completion of a single conversion or of a scan pass produces a one-cycle interrupt pulse and, when enabled, a matching DMA request pulse.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, run_bit, irq and dma_req are 0 and every stored result reads as 0.
- R2: With cfg_scan=0 an accepted start converts exactly the input cfg_chan once, after which busy and run_bit return to 0.
- R3: With cfg_scan=1 the inputs 0 up to N-1 are converted in ascending order, where cfg_grp code 0 gives N=4, code 1 gives N=8, and codes 2 and 3 give N=16.
- R4: The code on conv_data at the cycle conv_done is accepted is stored for the input being converted and is read on rd_data when rd_chan selects that input.
- R5: A scan with cfg_cont=0 stops after one pass, and run_bit clears when busy falls.
- R6: A scan with cfg_cont=1 returns to input 0 after input N-1 and keeps run_bit at 1 while it runs.
- R7: A sw_clr pulse during a scan lets the input in progress finish and store its result, then no further conversion starts and busy and run_bit drop to 0.
- R8: cfg_src picks the only start source honoured while idle: 0 is the sw_set pulse, 1 is the hw_evt strobe, 2 is a rising edge of ext_trig after a two-flop synchroniser, 3 accepts nothing; pulses on the other sources start nothing.
- R9: Start requests that arrive while busy is 1 start no extra conversion.
- R10: dma_req pulses together with irq when cfg_dma_en=1 and stays 0 when cfg_dma_en=0.
- R11: irq is a one-cycle pulse in the cycle after the conv_done that ends a single conversion or a scan pass, once per such event.
- R12: rd_data8 equals the upper eight bits, rd_data[9:2], of the selected result.
- R13: conv_start is a one-cycle pulse, and conv_chan holds its value until the matching conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scan | input | 1 | 0 single mode, 1 scan mode |
| cfg_cont | input | 1 | 1 repeats scan passes |
| cfg_grp | input | 2 | Scan group size code |
| cfg_chan | input | 4 | Input converted in single mode |
| cfg_src | input | 2 | Start source select |
| cfg_dma_en | input | 1 | Enables DMA request pulses |
| sw_set | input | 1 | Software start pulse |
| sw_clr | input | 1 | Software run-bit clear pulse |
| hw_evt | input | 1 | On-chip start event strobe |
| ext_trig | input | 1 | Asynchronous trigger pin |
| conv_start | output | 1 | Start pulse to the engine |
| conv_chan | output | 4 | Input to be converted |
| conv_done | input | 1 | Engine completion strobe |
| conv_data | input | 10 | Engine result code |
| rd_chan | input | 4 | Result read select |
| rd_data | output | 10 | Selected result, full width |
| rd_data8 | output | 8 | Selected result, upper eight bits |
| busy | output | 1 | Sequencer active |
| run_bit | output | 1 | Run bit state |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | Completion DMA request pulse |

## Verification
The hardest situation to reach from the ports is a clear that lands while a conversion is outstanding in the middle of a repeating scan, because it must fall after several passes and inside the engine's wait window rather than at an issue cycle. The bench model of the engine switches to a fixed, longer latency for that case, waits until three pass interrupts have been counted, then watches for the next start and drops the clear into the following wait cycles, so the expected stopping point is known exactly. Start pulses aimed at a busy sequencer and at non-selected sources are driven in directed runs, and random single and one-pass scan runs vary source, group, input and latency.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int NCH = 16;
    localparam int DW  = 10;
    localparam int CW  = $clog2(NCH);
    localparam int NARROW = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_HW   = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_NONE = 2'd3
    } start_src_e;

    typedef struct packed {
        logic          scan;
        logic          cont;
        logic [CW-1:0] last;
    } run_cfg_t;

    typedef struct packed {
        logic          we;
        logic [CW-1:0] ch;
        logic [DW-1:0] val;
    } res_wr_t;

    function automatic logic [CW-1:0] grp_last(input logic [1:0] code);
        case (code)
            2'd0:    return CW'(NCH / 4 - 1);
            2'd1:    return CW'(NCH / 2 - 1);
            default: return CW'(NCH - 1);
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
`timescale 1ns/1ps
module adc_trig_sync
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src,
    input  logic       idle,
    input  logic       sw_set,
    input  logic       hw_evt,
    input  logic       ext_pin,
    output logic       start_req
);

    logic [SYNC_STAGES:0] shreg;
    logic                 ext_rise;
    logic                 chosen;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SYNC_STAGES-1:0], ext_pin};
    end

    assign ext_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

    always_comb begin
        case (start_src_e'(src))
            SRC_SW:  chosen = sw_set;
            SRC_HW:  chosen = hw_evt;
            SRC_EXT: chosen = ext_rise;
            default: chosen = 1'b0;
        endcase
    end

    assign start_req = idle & chosen;

    // edge detector yields isolated single-cycle events (R8)
    assert_ext_edge_R8: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          cfg_scan,
    input  logic          cfg_cont,
    input  logic [1:0]    cfg_grp,
    input  logic [CW-1:0] cfg_chan,
    input  logic          sw_clr,
    input  logic          conv_done,
    output logic          conv_start,
    output logic [CW-1:0] conv_chan,
    output logic          busy,
    output logic          run_bit,
    output logic          pass_end,
    output res_wr_t       wr,
    input  logic [DW-1:0] conv_data
);

    seq_state_e    st;
    run_cfg_t      cfg_q;
    logic [CW-1:0] cur;
    logic          run_q;
    logic          keep_going;
    logic          at_last;
    logic          finish;
    logic          accept;
    logic [CW-1:0] next_ch;

    assign accept     = (st == ST_WAIT) && conv_done;
    assign keep_going = run_q & ~sw_clr;
    assign at_last    = (cur == cfg_q.last);
    assign finish     = !cfg_q.scan || !keep_going || (at_last && !cfg_q.cont);
    assign next_ch    = at_last ? '0 : cur + 1'b1;
    assign pass_end   = accept && (!cfg_q.scan || at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg_q <= '0;
            cur   <= '0;
            run_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_req) begin
                        cfg_q.scan <= cfg_scan;
                        cfg_q.cont <= cfg_cont;
                        cfg_q.last <= grp_last(cfg_grp);
                        cur        <= cfg_scan ? '0 : cfg_chan;
                        run_q      <= 1'b1;
                        st         <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    st <= ST_WAIT;
                    if (sw_clr) run_q <= 1'b0;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (finish) begin
                            st    <= ST_IDLE;
                            run_q <= 1'b0;
                        end else begin
                            cur   <= next_ch;
                            st    <= ST_ISSUE;
                        end
                    end else if (sw_clr) begin
                        run_q <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = (st == ST_ISSUE);
    assign conv_chan  = cur;
    assign busy       = (st != ST_IDLE);
    assign run_bit    = run_q;
    assign wr.we      = accept;
    assign wr.ch      = cur;
    assign wr.val     = conv_data;

    // checker state: channel of the previous start
    logic [CW-1:0] prev_ch;
    always_ff @(posedge clk) begin
        if (rst)             prev_ch <= '0;
        else if (conv_start) prev_ch <= conv_chan;
    end

    assert_start_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_chan_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_start && !conv_done) |=> $stable(conv_chan));

    assert_ascend_R3: assert property (@(posedge clk) disable iff (rst)
        (conv_start && cfg_q.scan && conv_chan != '0) |-> (conv_chan == CW'(prev_ch + 1'b1)));

    assert_run_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !run_bit);

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  res_wr_t           wr,
    input  logic [CW-1:0]     rd_chan,
    output logic [DW-1:0]     rd_data,
    output logic [NARROW-1:0] rd_data8
);

    logic [DW-1:0] bank [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             bank[g] <= '0;
            else if (wr.we && wr.ch == CW'(g))   bank[g] <= wr.val;
        end
    end

    assign rd_data  = bank[rd_chan];
    assign rd_data8 = rd_data[DW-1 -: NARROW];

    assert_store_R4: assert property (@(posedge clk) disable iff (rst)
        $past(wr.we) |-> (bank[$past(wr.ch)] == $past(wr.val)));

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_scan,
    input  logic              cfg_cont,
    input  logic [1:0]        cfg_grp,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [1:0]        cfg_src,
    input  logic              cfg_dma_en,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic              hw_evt,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [CW-1:0]     conv_chan,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_data,
    input  logic [CW-1:0]     rd_chan,
    output logic [DW-1:0]     rd_data,
    output logic [NARROW-1:0] rd_data8,
    output logic              busy,
    output logic              run_bit,
    output logic              irq,
    output logic              dma_req
);

    logic    start_req;
    logic    pass_end;
    res_wr_t wr;

    adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .src       (cfg_src),
        .idle      (!busy),
        .sw_set    (sw_set),
        .hw_evt    (hw_evt),
        .ext_pin   (ext_trig),
        .start_req (start_req)
    );

    adc_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .cfg_scan   (cfg_scan),
        .cfg_cont   (cfg_cont),
        .cfg_grp    (cfg_grp),
        .cfg_chan   (cfg_chan),
        .sw_clr     (sw_clr),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .busy       (busy),
        .run_bit    (run_bit),
        .pass_end   (pass_end),
        .wr         (wr),
        .conv_data  (conv_data)
    );

    adc_result_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_chan  (rd_chan),
        .rd_data  (rd_data),
        .rd_data8 (rd_data8)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            irq     <= pass_end;
            dma_req <= pass_end & cfg_dma_en;
        end
    end

    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_dma_gate_R10: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> irq);

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
    import adc_seq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, cfg_scan, cfg_cont, cfg_dma_en, sw_set, sw_clr, hw_evt, ext_trig;
    logic [1:0] cfg_grp, cfg_src;
    logic [3:0] cfg_chan, conv_chan, rd_chan;
    logic conv_start, conv_done, busy, run_bit, irq, dma_req;
    logic [9:0] conv_data, rd_data;
    logic [7:0] rd_data8;

    adc_scan_seq u0 (.*);

    int checks = 0, errs = 0;
    int log_chan [4096];
    int log_n = 0, irq_n = 0, dma_n = 0;
    int model [16];
    int fix_lat = 0;
    int cyc = 0;
    int last_done_cyc = -10;
    int eng_cnt = 0;
    logic [9:0] eng_val;
    logic prev_start = 1'b0;
    logic [3:0] busy_ch;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gsize(input int code);
        return (code == 0) ? 4 : (code == 1) ? 8 : 16;
    endfunction

    // engine model and monitors
    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            conv_done = 1'b0;
            if (eng_cnt > 0) begin
                eng_cnt--;
                if (eng_cnt == 0) begin
                    conv_done = 1'b1;
                    conv_data = eng_val;
                    last_done_cyc = cyc;
                    chk(conv_chan == busy_ch, "R13 chan held", conv_chan, busy_ch);
                end
            end
            if (conv_start) begin
                chk(!prev_start, "R13 start pulse", prev_start, 0);
                eng_val = 10'($urandom % 1024);
                busy_ch = conv_chan;
                if (log_n < 4096) log_chan[log_n] = conv_chan;
                log_n++;
                model[conv_chan] = eng_val;
                eng_cnt = (fix_lat != 0) ? fix_lat : 1 + int'($urandom % 4);
            end
            prev_start = conv_start;
            if (irq) begin
                irq_n++;
                chk(cyc == last_done_cyc + 1, "R11 irq timing", cyc, last_done_cyc + 1);
            end
            if (dma_req) dma_n++;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    task automatic fire(input int src);
        @(negedge clk);
        case (src)
            0: begin sw_set = 1'b1; @(negedge clk); sw_set = 1'b0; end
            1: begin hw_evt = 1'b1; @(negedge clk); hw_evt = 1'b0; end
            default: begin ext_trig = 1'b1; repeat (4) @(negedge clk); ext_trig = 1'b0; end
        endcase
    endtask

    task automatic wait_done(output bit ok);
        int t;
        ok = 1'b0;
        t = 0;
        while (!busy && t < 30) begin @(negedge clk); t++; end
        if (!busy) return;
        t = 0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        ok = !busy;
    endtask

    task automatic set_cfg(input bit scan, input bit cont, input int grp, input int ch,
                           input int src, input bit dma);
        @(negedge clk);
        cfg_scan = scan; cfg_cont = cont; cfg_grp = 2'(grp);
        cfg_chan = 4'(ch); cfg_src = 2'(src); cfg_dma_en = dma;
    endtask

    task automatic check_results(input int n0, input int n1);
        for (int k = n0; k < n1; k++) begin
            @(negedge clk);
            rd_chan = 4'(log_chan[k]);
            @(negedge clk);
            chk(rd_data == 10'(model[log_chan[k]]), "R4 stored", rd_data, model[log_chan[k]]);
            chk(rd_data8 == rd_data[9:2], "R12 narrow view", rd_data8, rd_data[9:2]);
        end
    endtask

    task automatic run_check(input string req, input bit scan, input int grp, input int ch,
                             input int src, input bit dma);
        int n0, i0, d0, len;
        bit ok;
        set_cfg(scan, 1'b0, grp, ch, src, dma);
        n0 = log_n; i0 = irq_n; d0 = dma_n;
        fire(src);
        wait_done(ok);
        chk(ok, "R8 started and finished", ok, 1);
        len = scan ? gsize(grp) : 1;
        chk(log_n - n0 == len, req, log_n - n0, len);
        for (int k = 0; k < len && k < log_n - n0; k++) begin
            int e;
            e = scan ? k : ch;
            chk(log_chan[n0 + k] == e, scan ? "R3 order" : "R2 channel", log_chan[n0 + k], e);
        end
        chk(irq_n - i0 == 1, "R11 irq count", irq_n - i0, 1);
        chk(dma_n - d0 == (dma ? 1 : 0), "R10 dma", dma_n - d0, dma ? 1 : 0);
        chk(run_bit == 1'b0, "R5 run bit cleared", run_bit, 0);
        check_results(n0, log_n);
    endtask

    initial begin
        bit ok;
        int n0, i0, nclr, exp_irq, t;
        void'($urandom(32'h5EED));
        rst = 1'b1; cfg_scan = 0; cfg_cont = 0; cfg_grp = 0; cfg_chan = 0; cfg_src = 0;
        cfg_dma_en = 0; sw_set = 0; sw_clr = 0; hw_evt = 0; ext_trig = 0; rd_chan = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !run_bit && !irq && !dma_req, "R1 flags", {busy, run_bit, irq, dma_req}, 0);
        for (int c = 0; c < 16; c++) begin
            rd_chan = 4'(c);
            @(negedge clk);
            chk(rd_data == 0, "R1 result", rd_data, 0);
        end

        // directed single and scan runs over all sources
        run_check("R2 single ch0", 1'b0, 0, 0, 0, 1'b1);
        run_check("R2 single ch15 ext", 1'b0, 0, 15, 2, 1'b1);
        run_check("R2 single hw", 1'b0, 3, 7, 1, 1'b0);
        run_check("R3 group4 hw", 1'b1, 0, 0, 1, 1'b1);
        run_check("R3 group8 ext", 1'b1, 1, 0, 2, 1'b1);
        run_check("R3 group16 code2", 1'b1, 2, 0, 0, 1'b1);
        run_check("R5 group16 code3 no dma", 1'b1, 3, 0, 0, 1'b0);

        // R8 non-selected sources ignored
        set_cfg(1'b1, 1'b0, 0, 0, 1, 1'b1);
        n0 = log_n;
        fire(0); fire(2);
        repeat (8) @(negedge clk);
        chk(log_n == n0 && !busy && !run_bit, "R8 hw selected, others ignored", log_n - n0, 0);
        set_cfg(1'b1, 1'b0, 0, 0, 3, 1'b1);
        fire(0); fire(1); fire(2);
        repeat (8) @(negedge clk);
        chk(log_n == n0 && !busy, "R8 code3 accepts nothing", log_n - n0, 0);

        // R9 starts while busy ignored
        fix_lat = 3;
        set_cfg(1'b1, 1'b0, 3, 0, 0, 1'b1);
        n0 = log_n; i0 = irq_n;
        fire(0);
        repeat (6) @(negedge clk);
        fire(0);
        repeat (10) @(negedge clk);
        fire(0);
        wait_done(ok);
        chk(log_n - n0 == 16, "R9 sw set while busy", log_n - n0, 16);
        chk(irq_n - i0 == 1, "R9 single pass irq", irq_n - i0, 1);
        set_cfg(1'b1, 1'b0, 1, 0, 1, 1'b0);
        n0 = log_n;
        fire(1);
        repeat (5) @(negedge clk);
        fire(1);
        wait_done(ok);
        chk(log_n - n0 == 8, "R9 hw event while busy", log_n - n0, 8);

        // R6 / R7 continuous scan, clear mid-pass
        fix_lat = 5;
        set_cfg(1'b1, 1'b1, 0, 0, 0, 1'b1);
        n0 = log_n; i0 = irq_n;
        fire(0);
        t = 0;
        while (irq_n - i0 < 3 && t < 5000) begin @(negedge clk); t++; end
        chk(irq_n - i0 >= 3, "R6 repeated passes", irq_n - i0, 3);
        chk(run_bit && busy, "R6 run bit held", run_bit, 1);
        nclr = log_n;
        t = 0;
        while (log_n == nclr && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        sw_clr = 1'b1;
        nclr = log_n;
        @(negedge clk);
        sw_clr = 1'b0;
        t = 0;
        while (busy && t < 200) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk(log_n == nclr, "R7 no start after clear", log_n, nclr);
        chk(!busy && !run_bit, "R7 stopped", {busy, run_bit}, 0);
        exp_irq = 0;
        for (int k = n0; k < log_n; k++) begin
            chk(log_chan[k] == (k - n0) % 4, "R6 wrap order", log_chan[k], (k - n0) % 4);
            if (log_chan[k] == 3) exp_irq++;
        end
        chk(irq_n - i0 == exp_irq, "R6 irq per pass", irq_n - i0, exp_irq);
        check_results(log_n - 1, log_n);

        // random mix
        fix_lat = 0;
        for (int it = 0; it < 24; it++) begin
            run_check("R3 random run", 1'($urandom % 2), int'($urandom % 4), int'($urandom % 16),
                      int'($urandom % 3), 1'($urandom % 2));
        end

        summary();
        $finish;
    end

endmodule